// File: doc/BRIEF.md
# UART receive framer with break and framing recovery

This block turns an asynchronous serial line into received characters. The line is sampled on a 16x bit-rate enable pulse. A falling edge is confirmed at mid-bit. The block then collects 5 to 8 data bits, least significant bit first, and an optional parity bit. Each character is handed on as a one-cycle strobe. The strobe carries the data and three tags: parity error, framing error and break. The 16x enable comes from an external baud divider. Word length, parity enable, parity sense and stop-bit count are static configuration inputs. The block samples them when it accepts a start bit.

Two recovery behaviours set this block apart from a plain receiver. A character can end with a low stop bit. If it has any high data or parity sample, that low stop bit is taken as the start of the next character, and data sampling continues without waiting for a new falling edge. If the whole character was low and the line stays low past the character time, the block reports one all-zero break character. It then stays silent until the line has been high for half a bit time.

Top module: `uart_rx_core`

## Requirements
- R1: After reset `char_valid` is 0, and no character is produced while the line stays high.
- R2: A low on the line is accepted as a start bit only if it is still low at the 8th enable pulse after it is first seen (mid-bit). A low of 8 pulses or fewer produces no character.
- R3: Data bits are sampled at mid-bit, least significant bit first. `cfg_wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. In `char_data`, the bits above the word length are 0.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 means even parity and 1 means odd. `char_perr` is 1 exactly when the received parity bit breaks the selected rule, and it is always 0 when parity is off.
- R5: `char_ferr` is 1 when the first stop bit is sampled low.
- R6: After a framing error on a character with at least one high sample, the low stop bit counts as a confirmed start bit. The next data bit is sampled 16 pulses later, with no new falling edge needed.
- R7: If the start, data, parity and first stop samples are all low, and the line stays low for 8 further pulses, exactly one character is delivered: data 0, `char_brk`=1, `char_ferr`=1, `char_perr`=0. It is delivered once however long the line stays low. If the line rises within those 8 pulses, a data-0 character is delivered instead, with `char_ferr`=1 and `char_brk`=0.
- R8: After a break, the block accepts a new start bit only after 8 consecutive high pulses. Any shorter high period is ignored.
- R9: With `cfg_stop2`=1, only the first stop bit is checked. The line is ignored for 20 pulses after the first stop sample, so a low second stop bit sets no flag and produces no character.
- R10: `char_valid` is high for exactly one clock per character. It is raised on the enable pulse that samples the first stop bit, or on the pulse that decides a break.
- R11: Configuration is sampled when the start bit is confirmed. Changing it mid-character does not affect that character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| cfg_wlen | input | 2 | Word length code, 0..3 for 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop2 | input | 1 | Two stop bits |
| char_valid | output | 1 | One-cycle character strobe |
| char_data | output | 8 | Received character, LSB aligned |
| char_perr | output | 1 | Parity error tag |
| char_ferr | output | 1 | Framing error tag |
| char_brk | output | 1 | Break tag |

## Verification
The hardest case to reach is the edge of the break decision. An all-zero character whose line rises one pulse too early must come out as a plain framing error. Re-arming after a break must ignore a high period that is one pulse short of half a bit. Directed sequences hold the line low for exactly the character time plus seven pulses, and high for exactly seven pulses between long lows. Each bit time is a whole number of enable pulses, so these windows land on the boundary whatever the synchronizer phase. Framing recovery is driven by a frame whose stop bit is low, followed at once by the next character's data bits with no start bit of its own.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
// uart_rx_pkg: shared types for the UART receive framer.
// Assumes a maximum word of 8 bits, selected by a 2-bit length code.
package uart_rx_pkg;

    localparam int WORD_MAX = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2,
        ST_BRKCHK,
        ST_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } rx_cfg_t;

endpackage

// File: rtl/rx_line_sync.sv
`timescale 1ns/1ps
// rx_line_sync: brings the asynchronous serial line into the clock domain.
// Assumes the line idles high, so the reset value is high.
// STAGES = 0 gives a plain wire for already-synchronous sources.
module rx_line_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_chain
            logic [STAGES-1:0] sr;

            // shift the line through the synchronizer stages
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sr <= {STAGES{RESET_VAL}};
                end else begin
                    sr[0] <= din;
                    for (int i = 1; i < STAGES; i++) begin
                        sr[i] <= sr[i-1];
                    end
                end
            end

            assign dout = sr[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rx_parity_chk.sv
`timescale 1ns/1ps
// rx_parity_chk: decides whether a received parity bit is wrong.
// Assumes unused upper data bits are already zero, so they add nothing to the sum.
module rx_parity_chk #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          par_bit,
    input  logic          odd,
    input  logic          en,
    output logic          err
);

    logic ones_odd;

    // parity of data plus received parity bit, compared with the chosen sense
    always_comb begin
        ones_odd = (^data) ^ par_bit;
        err      = en & (ones_odd ^ odd);
    end

endmodule

// File: rtl/rx_frame_fsm.sv
`timescale 1ns/1ps
// rx_frame_fsm: character framing state machine.
// Confirms start bits at mid-bit, collects data and parity bits, checks the
// first stop bit, resynchronises on a framing error, and handles break.
// Assumes tick is a one-cycle enable at OVS times the bit rate and that
// rxd_s is already synchronous.
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rxd_s,
    input  rx_cfg_t             cfg_in,
    input  logic                par_err,
    output rx_cfg_t             cfg_q,
    output logic [WORD_MAX-1:0] data_q,
    output logic                par_bit_q,
    output logic                out_valid,
    output logic [WORD_MAX-1:0] out_data,
    output logic                out_perr,
    output logic                out_ferr,
    output logic                out_brk
);

    localparam int HALF   = OVS / 2;
    localparam int S2WAIT = OVS + OVS / 4;
    localparam int CNT_W  = $clog2(S2WAIT + 1);
    localparam int IDX_W  = $clog2(WORD_MAX);
    localparam logic [CNT_W-1:0] C_HALF = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] C_FULL = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] C_S2   = CNT_W'(S2WAIT - 1);

    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] bit_idx;
    logic             all_zero;
    logic [IDX_W-1:0] last_idx;

    // index of the final data bit for the latched word length
    always_comb begin
        last_idx = IDX_W'(4) + IDX_W'(cfg_q.wlen);
    end

    // framing sequence, advanced only on oversampling pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            all_zero  <= 1'b0;
            cfg_q     <= '0;
            data_q    <= '0;
            par_bit_q <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_perr  <= 1'b0;
            out_ferr  <= 1'b0;
            out_brk   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rxd_s) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end

                    ST_START: begin
                        if (cnt == C_HALF) begin
                            cnt <= '0;
                            if (!rxd_s) begin
                                state     <= ST_DATA;
                                bit_idx   <= '0;
                                data_q    <= '0;
                                par_bit_q <= 1'b0;
                                all_zero  <= 1'b1;
                                cfg_q     <= cfg_in;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end

                    ST_DATA: begin
                        if (cnt == C_FULL) begin
                            cnt             <= '0;
                            data_q[bit_idx] <= rxd_s;
                            if (rxd_s) all_zero <= 1'b0;
                            if (bit_idx == last_idx) begin
                                state <= cfg_q.par_en ? ST_PAR : ST_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end

                    ST_PAR: begin
                        if (cnt == C_FULL) begin
                            cnt       <= '0;
                            par_bit_q <= rxd_s;
                            if (rxd_s) all_zero <= 1'b0;
                            state     <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end

                    ST_STOP: begin
                        if (cnt == C_FULL) begin
                            cnt <= '0;
                            if (rxd_s) begin
                                out_valid <= 1'b1;
                                out_data  <= data_q;
                                out_perr  <= par_err;
                                out_ferr  <= 1'b0;
                                out_brk   <= 1'b0;
                                state     <= cfg_q.stop2 ? ST_STOP2 : ST_IDLE;
                            end else if (all_zero) begin
                                state <= ST_BRKCHK;
                            end else begin
                                out_valid <= 1'b1;
                                out_data  <= data_q;
                                out_perr  <= par_err;
                                out_ferr  <= 1'b1;
                                out_brk   <= 1'b0;
                                state     <= ST_DATA;
                                bit_idx   <= '0;
                                data_q    <= '0;
                                par_bit_q <= 1'b0;
                                all_zero  <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end

                    ST_STOP2: begin
                        if (cnt == C_S2) begin
                            cnt   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end

                    ST_BRKCHK: begin
                        if (rxd_s) begin
                            out_valid <= 1'b1;
                            out_data  <= data_q;
                            out_perr  <= par_err;
                            out_ferr  <= 1'b1;
                            out_brk   <= 1'b0;
                            cnt       <= '0;
                            state     <= ST_IDLE;
                        end else if (cnt == C_HALF) begin
                            out_valid <= 1'b1;
                            out_data  <= '0;
                            out_perr  <= 1'b0;
                            out_ferr  <= 1'b1;
                            out_brk   <= 1'b1;
                            cnt       <= '0;
                            state     <= ST_BRKWAIT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end

                    ST_BRKWAIT: begin
                        if (!rxd_s) begin
                            cnt <= '0;
                        end else if (cnt == C_HALF) begin
                            cnt   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end

                    default: begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end
                endcase
            end
        end
    end

    // R2: a start candidate that is high at mid-bit is dropped
    assert_glitch_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && tick && cnt == C_HALF && rxd_s) |=> state == ST_IDLE)
        else $error("start glitch accepted");

    // R3: a 5-bit word leaves the upper three data bits clear
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_q.wlen == 2'd0) |-> out_data[7:5] == 3'b000)
        else $error("upper bits set on short word");

    // R6: a low stop bit after a non-zero character resumes data sampling
    assert_ferr_resync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && tick && cnt == C_FULL && !rxd_s && !all_zero) |=> state == ST_DATA)
        else $error("no resync after framing error");

    // R7: a break character is all zero with framing tag and no parity tag
    assert_break_char_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_brk) |-> (out_data == '0 && out_ferr && !out_perr))
        else $error("malformed break character");

    // R8: a low sample while waiting after break keeps the block waiting
    assert_rearm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRKWAIT && tick && !rxd_s) |=> state == ST_BRKWAIT)
        else $error("re-armed while line low");

    // R9: nothing is delivered while the second stop bit is skipped
    assert_stop2_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP2 && $past(state) == ST_STOP2) |-> !out_valid)
        else $error("output during second stop bit");

    // R10: the character strobe never lasts two clocks
    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid)
        else $error("strobe wider than one clock");

endmodule

// File: rtl/uart_rx_core.sv
`timescale 1ns/1ps
// uart_rx_core: UART receive framer top level.
// Synchronises the line, runs the framing state machine and checks parity.
// Assumes tick16 is a one-cycle pulse at 16x the bit rate (OVERSAMPLE
// pulses per bit) and that configuration changes only between characters.
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       tick16,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_stop2,
    output logic       char_valid,
    output logic [7:0] char_data,
    output logic       char_perr,
    output logic       char_ferr,
    output logic       char_brk
);

    logic                rxd_s;
    rx_cfg_t             cfg_in;
    rx_cfg_t             cfg_q;
    logic [WORD_MAX-1:0] data_q;
    logic                par_bit_q;
    logic                par_err;

    // gather the configuration pins into one record
    always_comb begin
        cfg_in.wlen    = cfg_wlen;
        cfg_in.par_en  = cfg_par_en;
        cfg_in.par_odd = cfg_par_odd;
        cfg_in.stop2   = cfg_stop2;
    end

    rx_line_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rxd_s)
    );

    rx_parity_chk #(
        .DW (WORD_MAX)
    ) i_par (
        .data    (data_q),
        .par_bit (par_bit_q),
        .odd     (cfg_q.par_odd),
        .en      (cfg_q.par_en),
        .err     (par_err)
    );

    rx_frame_fsm #(
        .OVS (OVERSAMPLE)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .rxd_s     (rxd_s),
        .cfg_in    (cfg_in),
        .par_err   (par_err),
        .cfg_q     (cfg_q),
        .data_q    (data_q),
        .par_bit_q (par_bit_q),
        .out_valid (char_valid),
        .out_data  (char_data),
        .out_perr  (char_perr),
        .out_ferr  (char_ferr),
        .out_brk   (char_brk)
    );

endmodule

// File: tb/test_uart_rx_core.sv
`timescale 1ns/1ps
// test_uart_rx_core: directed corner cases plus seeded random frames.
module test_uart_rx_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick16;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       char_valid;
    logic [7:0] char_data;
    logic       char_perr;
    logic       char_ferr;
    logic       char_brk;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] div = 2'd0;

    uart_rx_core i_uart_rx_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd         (rxd),
        .tick16      (tick16),
        .cfg_wlen    (cfg_wlen),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_stop2   (cfg_stop2),
        .char_valid  (char_valid),
        .char_data   (char_data),
        .char_perr   (char_perr),
        .char_ferr   (char_ferr),
        .char_brk    (char_brk)
    );

    // 200 MHz clock
    always #2.5 clk = ~clk;

    // 16x enable: one clock in four, changed away from the active edge
    always @(negedge clk) div <= div + 2'd1;
    assign tick16 = (div == 2'd0);

    // capture every delivered character and note any strobe wider than one clock
    logic [7:0] q_data [0:255];
    logic [2:0] q_tags [0:255];
    int   rx_n = 0;
    int   wide_pulses = 0;
    logic prev_v = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (char_valid) begin
                if (rx_n < 256) begin
                    q_data[rx_n] = char_data;
                    q_tags[rx_n] = {char_perr, char_ferr, char_brk};
                end
                rx_n++;
                if (prev_v) wide_pulses++;
            end
            prev_v = char_valid;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_count(input int exp, input string tag);
        check(rx_n == exp, tag, "character count", rx_n, exp);
    endtask

    task automatic expect_char(input int idx, input logic [7:0] d, input logic pe,
                               input logic fe, input logic bk, input string tag);
        logic [10:0] act;
        logic [10:0] exp;
        exp = {d, pe, fe, bk};
        act = (idx < rx_n && idx < 256) ? {q_data[idx], q_tags[idx]} : 11'h7FF;
        check(idx < rx_n && act == exp, tag, "character {data,perr,ferr,brk}",
              32'(act), 32'(exp));
    endtask

    function automatic logic [7:0] word_mask(input logic [1:0] wl);
        return 8'hFF >> (2'd3 - wl);
    endfunction

    function automatic logic good_parity(input logic [7:0] d, input logic [1:0] wl,
                                         input logic odd);
        return (^(d & word_mask(wl))) ^ odd;
    endfunction

    // hold the line at one level for n enable pulses
    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n * 4) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic [1:0] wl, input logic pen,
                              input logic podd, input logic s2, input logic flip,
                              input logic stop_v, input logic stop2_v, input logic mid_cfg);
        cfg_wlen = wl; cfg_par_en = pen; cfg_par_odd = podd; cfg_stop2 = s2;
        hold(1'b0, 16);
        if (mid_cfg) begin
            cfg_wlen = ~wl; cfg_par_en = ~pen; cfg_stop2 = ~s2;
        end
        for (int i = 0; i < 5 + int'(wl); i++) hold(d[i], 16);
        if (pen) hold(good_parity(d, wl, podd) ^ flip, 16);
        hold(stop_v, 16);
        if (s2) hold(stop2_v, 16);
        cfg_wlen = wl; cfg_par_en = pen; cfg_par_odd = podd; cfg_stop2 = s2;
    endtask

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd20240611));
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        hold(1'b1, 24);

        // R1: quiet after reset with the line high
        check(char_valid == 1'b0, "R1", "char_valid after reset", 32'(char_valid), 0);
        expect_count(0, "R1");

        // R2: lows of 4 and 8 pulses are glitches
        hold(1'b0, 4);  hold(1'b1, 24);
        hold(1'b0, 8);  hold(1'b1, 24);
        expect_count(0, "R2");

        // R3: LSB first, masked word lengths
        base = rx_n;
        send_frame(8'h15, 2'd0, 0, 0, 0, 0, 1, 1, 0); hold(1'b1, 8);
        send_frame(8'hA5, 2'd3, 0, 0, 0, 0, 1, 1, 0); hold(1'b1, 8);
        send_frame(8'hFF, 2'd1, 0, 0, 0, 0, 1, 1, 0); hold(1'b1, 8);
        expect_count(base + 3, "R3");
        expect_char(base,     8'h15, 0, 0, 0, "R3");
        expect_char(base + 1, 8'hA5, 0, 0, 0, "R3");
        expect_char(base + 2, 8'h3F, 0, 0, 0, "R3");

        // R4: even and odd parity, good and flipped
        base = rx_n;
        send_frame(8'h4B, 2'd2, 1, 0, 0, 0, 1, 1, 0); hold(1'b1, 8);
        send_frame(8'h4B, 2'd2, 1, 0, 0, 1, 1, 1, 0); hold(1'b1, 8);
        send_frame(8'h96, 2'd3, 1, 1, 0, 0, 1, 1, 0); hold(1'b1, 8);
        send_frame(8'h96, 2'd3, 1, 1, 0, 1, 1, 1, 0); hold(1'b1, 8);
        expect_char(base,     8'h4B, 0, 0, 0, "R4");
        expect_char(base + 1, 8'h4B, 1, 0, 0, "R4");
        expect_char(base + 2, 8'h96, 0, 0, 0, "R4");
        expect_char(base + 3, 8'h96, 1, 0, 0, "R4");

        // R5 and R6: low stop bit, next data follows with no start bit
        base = rx_n;
        cfg_wlen = 2'd3; cfg_par_en = 0; cfg_stop2 = 0;
        hold(1'b0, 16);
        for (int i = 0; i < 8; i++) hold(logic'((8'h3C >> i) & 8'h01), 16);
        hold(1'b0, 16);
        for (int i = 0; i < 8; i++) hold(logic'((8'h5A >> i) & 8'h01), 16);
        hold(1'b1, 16); hold(1'b1, 8);
        expect_count(base + 2, "R6");
        expect_char(base,     8'h3C, 0, 1, 0, "R5");
        expect_char(base + 1, 8'h5A, 0, 0, 0, "R6");

        // R7: long low gives one break; zero char with good stop is no break
        base = rx_n;
        hold(1'b0, 3 * 176); hold(1'b1, 16);
        expect_count(base + 1, "R7");
        expect_char(base, 8'h00, 0, 1, 1, "R7");
        send_frame(8'h00, 2'd3, 0, 0, 0, 0, 1, 1, 0); hold(1'b1, 8);
        expect_char(base + 1, 8'h00, 0, 0, 0, "R7");
        // all-zero char whose line rises one pulse before the break decision
        send_frame(8'h00, 2'd3, 0, 0, 0, 0, 0, 1, 0); hold(1'b1, 16);
        expect_count(base + 3, "R7");
        expect_char(base + 2, 8'h00, 0, 1, 0, "R7");

        // R8: seven high pulses after break do not re-arm, eight do
        base = rx_n;
        hold(1'b0, 600); hold(1'b1, 7); hold(1'b0, 200); hold(1'b1, 8);
        send_frame(8'h81, 2'd3, 0, 0, 0, 0, 1, 1, 0); hold(1'b1, 8);
        expect_count(base + 2, "R8");
        expect_char(base,     8'h00, 0, 1, 1, "R8");
        expect_char(base + 1, 8'h81, 0, 0, 0, "R8");

        // R9: second stop bit low is not checked
        base = rx_n;
        send_frame(8'h6E, 2'd3, 1, 1, 1, 0, 1, 0, 0); hold(1'b1, 24);
        expect_count(base + 1, "R9");
        expect_char(base, 8'h6E, 0, 0, 0, "R9");

        // R11: configuration changed after the start bit is not used
        base = rx_n;
        send_frame(8'hC3, 2'd3, 0, 0, 0, 0, 1, 1, 1); hold(1'b1, 8);
        expect_count(base + 1, "R11");
        expect_char(base, 8'hC3, 0, 0, 0, "R11");

        // R3/R4/R9: seeded random frames with random configuration
        for (int k = 0; k < 60; k++) begin
            logic [7:0] d;
            logic [1:0] wl;
            logic pen, podd, s2, flip;
            d    = 8'($urandom);
            wl   = 2'($urandom_range(0, 3));
            pen  = 1'($urandom_range(0, 1));
            podd = 1'($urandom_range(0, 1));
            s2   = 1'($urandom_range(0, 1));
            flip = ($urandom_range(0, 3) == 0);
            base = rx_n;
            send_frame(d, wl, pen, podd, s2, flip, 1, 1, 0);
            hold(1'b1, 1 + $urandom_range(0, 15));
            expect_char(base, d & word_mask(wl), pen & flip, 0, 0, "R4");
        end

        // R10: every strobe lasted exactly one clock
        check(wide_pulses == 0, "R10", "wide strobes", 32'(wide_pulses), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule